// File: doc/BRIEF.md
# Floppy Controller Powerdown Wake Logic

This block sits next to a floppy disk controller and watches the host's accesses to the controller's eight-byte register window while the controller may be in automatic powerdown. For each access it decides whether the access is a wake event. That decision depends on three things: the register offset, whether the access is a read or a write, and for some writes the value written. The block holds a powered-down flag. An external request pulse sets the flag, and a qualifying access clears it. While the flag is set, the block pulls the output enables of the drive pins that carry write data and write gating, so those pins float. The other drive outputs stay driven.

The host side is a simple synchronous bus: a 3-bit offset, separate read and write strobes, and 8-bit write data. Read and write strobes may be asserted together, and the block then judges each of them on its own. The register contents, the data path and the host bus engine are outside this block.

Top module: `fdc_pd_wake`

## Requirements
- R1: An access never wakes the part when it is a read at offset 0, 1 or 7, a write at offset 7, or any access at offset 3 or 6.
- R2: A read at offset 4 (main status) is a wake event.
- R3: A read or a write at offset 5 (data) is a wake event.
- R4: A write at offset 2 is a wake event exactly when write data bits [7:4] (motor enables) are not all zero, or bit 2 (active-low reset) is zero.
- R5: A write at offset 4 (rate select) is a wake event exactly when write data bit 7 (software reset) is one.
- R6: `wake` is high combinationally in the cycle a wake event is presented, and only while `pd_flag` is high. `pd_flag` is then low after the next rising clock edge.
- R7: A `pd_req` pulse sets `pd_flag` at the next edge when no wake event is present in the same cycle. If a wake event is present in that cycle, `pd_flag` is low after the edge.
- R8: `drv_oe` has one bit per drive output. Bit 4 (write data) and bit 5 (write gate) are low while `pd_flag` is high. Bits 0 to 3, 6 and 7 are always high.
- R9: Synchronous active-high `rst` leaves `pd_flag` low and every bit of `drv_oe` high after the edge, even if `pd_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ofs | input | 3 | Register offset of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| pd_req | input | 1 | Powerdown request pulse |
| pd_flag | output | 1 | Controller is powered down |
| wake | output | 1 | Single-cycle wake pulse |
| drv_oe | output | 8 | Output enables for the drive pins |

## Verification
A powerdown request and a wake-qualifying access can arrive in the same cycle. The bench drives `pd_req` together with a data-register read, and separately together with a status read that does not wake the part. It does this both from the awake state and from the powered-down state. The flag after the edge must be low in the first case and high in the second. Beyond that, the bench sweeps every offset, every strobe combination and every write byte in both power states, and compares `wake`, `pd_flag` and `drv_oe` against a model computed from the bit rules.

// File: rtl/fdc_pd_pkg.sv
package fdc_pd_pkg;

    localparam int OFS_W  = 3;
    localparam int DATA_W = 8;
    localparam int NPINS  = 8;

    typedef enum logic [OFS_W-1:0] {
        OFS_STAT_A  = 3'd0,
        OFS_STAT_B  = 3'd1,
        OFS_DRVCTL  = 3'd2,
        OFS_GAP3    = 3'd3,
        OFS_STAT_RS = 3'd4,
        OFS_FIFO    = 3'd5,
        OFS_GAP6    = 3'd6,
        OFS_INP_CFG = 3'd7
    } fdc_ofs_e;

    // drive pin slots in drv_oe
    localparam int PIN_MOTOR = 0;
    localparam int PIN_SEL   = 1;
    localparam int PIN_DIR   = 2;
    localparam int PIN_STEP  = 3;
    localparam int PIN_WDAT  = 4;
    localparam int PIN_WGATE = 5;
    localparam int PIN_HEAD  = 6;
    localparam int PIN_DENS  = 7;

    localparam logic [NPINS-1:0] TRI_DEFAULT =
        (NPINS'(1) << PIN_WDAT) | (NPINS'(1) << PIN_WGATE);

    typedef struct packed {
        logic              rd;
        logic              wr;
        fdc_ofs_e          ofs;
        logic [DATA_W-1:0] wdata;
    } fdc_acc_t;

    typedef struct packed {
        logic rd_wake;
        logic wr_wake;
    } fdc_wake_t;

    typedef struct packed {
        logic pd;
        logic wake;
    } fdc_pwr_t;

    function automatic logic any_in_field(input logic [DATA_W-1:0] d,
                                          input int lsb, input int cnt);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i >= lsb && i < lsb + cnt) acc = acc | d[i];
        end
        return acc;
    endfunction

    function automatic logic bit_at(input logic [DATA_W-1:0] d, input int pos);
        logic v;
        v = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i == pos) v = d[i];
        end
        return v;
    endfunction

    function automatic logic rd_is_wake(input fdc_ofs_e o);
        return (o == OFS_STAT_RS) || (o == OFS_FIFO);
    endfunction

endpackage

// File: rtl/fdc_pd_decode.sv
module fdc_pd_decode
    import fdc_pd_pkg::*;
#(
    parameter int MOTOR_LSB   = 4,
    parameter int MOTOR_CNT   = 4,
    parameter int DRV_RST_BIT = 2,
    parameter int RS_RST_BIT  = 7
) (
    input  fdc_acc_t  acc,
    output fdc_wake_t evt
);
    logic motor_on;
    logic drv_rst_n;
    logic rs_rst;

    always_comb begin
        motor_on  = any_in_field(acc.wdata, MOTOR_LSB, MOTOR_CNT);
        drv_rst_n = bit_at(acc.wdata, DRV_RST_BIT);
        rs_rst    = bit_at(acc.wdata, RS_RST_BIT);
    end

    always_comb begin
        evt.rd_wake = acc.rd && rd_is_wake(acc.ofs);
        evt.wr_wake = 1'b0;
        if (acc.wr) begin
            unique case (acc.ofs)
                OFS_DRVCTL:  evt.wr_wake = motor_on || !drv_rst_n;
                OFS_STAT_RS: evt.wr_wake = rs_rst;
                OFS_FIFO:    evt.wr_wake = 1'b1;
                default:     evt.wr_wake = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fdc_pd_state.sv
module fdc_pd_state
    import fdc_pd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wake_evt,
    input  logic     pd_req,
    output fdc_pwr_t pwr
);
    logic pd_q;

    always_ff @(posedge clk) begin
        if (rst)            pd_q <= 1'b0;
        else if (wake_evt)  pd_q <= 1'b0;
        else if (pd_req)    pd_q <= 1'b1;
    end

    always_comb begin
        pwr.pd   = pd_q;
        pwr.wake = pd_q && wake_evt;
    end
endmodule

// File: rtl/fdc_pd_pins.sv
module fdc_pd_pins
    import fdc_pd_pkg::*;
#(
    parameter int              N        = NPINS,
    parameter logic [N-1:0]    TRI_MASK = N'(TRI_DEFAULT)
) (
    input  logic         pd,
    output logic [N-1:0] oe
);
    for (genvar p = 0; p < N; p++) begin : g_pin
        if (TRI_MASK[p]) begin : g_float
            assign oe[p] = !pd;
        end else begin : g_drive
            assign oe[p] = 1'b1;
        end
    end
endmodule

// File: rtl/fdc_pd_wake.sv
module fdc_pd_wake
    import fdc_pd_pkg::*;
#(
    parameter int               MOTOR_LSB   = 4,
    parameter int               MOTOR_CNT   = 4,
    parameter int               DRV_RST_BIT = 2,
    parameter int               RS_RST_BIT  = 7,
    parameter logic [NPINS-1:0] TRI_MASK    = TRI_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  bus_ofs,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              pd_req,
    output logic              pd_flag,
    output logic              wake,
    output logic [NPINS-1:0]  drv_oe
);
    fdc_acc_t  acc;
    fdc_wake_t evt;
    fdc_pwr_t  pwr;
    logic      wake_evt;

    always_comb begin
        acc.rd    = bus_rd;
        acc.wr    = bus_wr;
        acc.ofs   = fdc_ofs_e'(bus_ofs);
        acc.wdata = bus_wdata;
    end

    fdc_pd_decode #(
        .MOTOR_LSB   (MOTOR_LSB),
        .MOTOR_CNT   (MOTOR_CNT),
        .DRV_RST_BIT (DRV_RST_BIT),
        .RS_RST_BIT  (RS_RST_BIT)
    ) u_dec (
        .acc (acc),
        .evt (evt)
    );

    assign wake_evt = evt.rd_wake || evt.wr_wake;

    fdc_pd_state u_state (
        .clk      (clk),
        .rst      (rst),
        .wake_evt (wake_evt),
        .pd_req   (pd_req),
        .pwr      (pwr)
    );

    fdc_pd_pins #(
        .N        (NPINS),
        .TRI_MASK (TRI_MASK)
    ) u_pins (
        .pd (pwr.pd),
        .oe (drv_oe)
    );

    assign pd_flag = pwr.pd;
    assign wake    = pwr.wake;
endmodule

// File: rtl/fdc_pd_wake_chk.sv
module fdc_pd_wake_chk
    import fdc_pd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OFS_W-1:0]  bus_ofs,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              pd_req,
    input logic              pd_flag,
    input logic              wake,
    input logic [NPINS-1:0]  drv_oe,
    input logic              wake_evt
);
    logic quiet_ofs;
    assign quiet_ofs = (bus_ofs == 3'd0) || (bus_ofs == 3'd1) || (bus_ofs == 3'd3)
                    || (bus_ofs == 3'd6) || (bus_ofs == 3'd7);

    assert_quiet_ofs_R1: assert property (@(posedge clk) disable iff (rst)
        quiet_ofs |-> !wake);

    assert_msr_read_R2: assert property (@(posedge clk) disable iff (rst)
        (pd_flag && bus_rd && bus_ofs == 3'd4) |-> wake);

    assert_fifo_any_R3: assert property (@(posedge clk) disable iff (rst)
        (pd_flag && (bus_rd || bus_wr) && bus_ofs == 3'd5) |-> wake);

    assert_drvctl_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && bus_ofs == 3'd2 && bus_wdata[7:4] == 4'd0 && bus_wdata[2])
            |-> !wake);

    assert_rs_noreset_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && bus_ofs == 3'd4 && !bus_wdata[7]) |-> !wake);

    assert_wake_needs_pd_R6: assert property (@(posedge clk) disable iff (rst)
        wake |-> pd_flag);

    assert_wake_clears_R6: assert property (@(posedge clk) disable iff (rst)
        wake |=> !pd_flag);

    assert_req_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (pd_req && !wake_evt) |=> pd_flag);

    assert_evt_beats_req_R7: assert property (@(posedge clk) disable iff (rst)
        wake_evt |=> !pd_flag);

    assert_write_pins_float_R8: assert property (@(posedge clk) disable iff (rst)
        pd_flag |-> (!drv_oe[4] && !drv_oe[5]));

    assert_other_pins_drive_R8: assert property (@(posedge clk) disable iff (rst)
        (drv_oe[3:0] == 4'hF) && (drv_oe[7:6] == 2'b11));

    assert_reset_state_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pd_flag && drv_oe == '1));
endmodule

bind fdc_pd_wake fdc_pd_wake_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_ofs   (bus_ofs),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pd_req    (pd_req),
    .pd_flag   (pd_flag),
    .wake      (wake),
    .drv_oe    (drv_oe),
    .wake_evt  (wake_evt)
);

// File: tb/fdc_pd_wake_test.sv
`timescale 1ns/1ps
module fdc_pd_wake_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_ofs = 3'd0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic       pd_req = 1'b0;
    logic       pd_flag;
    logic       wake;
    logic [7:0] drv_oe;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    fdc_pd_wake uut (
        .clk       (clk),
        .rst       (rst),
        .bus_ofs   (bus_ofs),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pd_req    (pd_req),
        .pd_flag   (pd_flag),
        .wake      (wake),
        .drv_oe    (drv_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_wake_evt(input bit rd, input bit wr, input int o, input int d);
        bit e;
        e = 0;
        if (rd && (o == 4 || o == 5)) e = 1;
        if (wr && o == 5) e = 1;
        if (wr && o == 2 && ((d / 16) != 0 || ((d / 4) % 2) == 0)) e = 1;
        if (wr && o == 4 && d >= 128) e = 1;
        return e;
    endfunction

    function automatic string req_of(input bit rd, input bit wr, input int o);
        if (o == 5) return "R3";
        if (o == 4 && rd) return "R2";
        if (o == 4) return "R5";
        if (o == 2 && wr) return "R4";
        return "R1";
    endfunction

    function automatic int exp_oe(input bit pd);
        return pd ? 8'hCF : 8'hFF;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic enter_pd();
        @(negedge clk);
        pd_req = 1'b1;
        @(posedge clk);
        #1;
        chk(pd_flag === 1'b1, "R7", "pd_flag after request", int'(pd_flag), 1);
        chk(drv_oe === 8'hCF, "R8", "drv_oe in powerdown", int'(drv_oe), 8'hCF);
        @(negedge clk);
        pd_req = 1'b0;
    endtask

    task automatic one_access(input bit pd, input bit rd, input bit wr,
                              input int o, input int d, input bit req);
        bit    ev;
        bit    exp_flag;
        string r;
        if (pd) enter_pd(); else do_reset();
        ev = exp_wake_evt(rd, wr, o, d);
        r  = req_of(rd, wr, o);
        @(negedge clk);
        bus_ofs   = 3'(o);
        bus_rd    = rd;
        bus_wr    = wr;
        bus_wdata = 8'(d);
        pd_req    = req;
        #1;
        chk(wake === (ev && pd), r, "wake pulse (R6)", int'(wake), int'(ev && pd));
        chk(drv_oe === 8'(exp_oe(pd)), "R8", "drv_oe during access", int'(drv_oe), exp_oe(pd));
        @(posedge clk);
        #1;
        exp_flag = ev ? 1'b0 : (pd || req);
        chk(pd_flag === exp_flag, req ? "R7" : "R6", "pd_flag after access",
            int'(pd_flag), int'(exp_flag));
        @(negedge clk);
        chk(wake === 1'b0, "R6", "wake is single cycle", int'(wake), 0);
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        pd_req = 1'b0;
    endtask

    initial begin : watchdog
        #1_500_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(pd_flag === 1'b0, "R9", "pd_flag after reset", int'(pd_flag), 0);
        chk(drv_oe === 8'hFF, "R9", "drv_oe after reset", int'(drv_oe), 8'hFF);

        // reset dominates a pending request, and clears powerdown
        enter_pd();
        @(negedge clk);
        rst = 1'b1;
        pd_req = 1'b1;
        @(posedge clk);
        #1;
        chk(pd_flag === 1'b0, "R9", "reset with request held", int'(pd_flag), 0);
        chk(drv_oe === 8'hFF, "R9", "drv_oe under reset", int'(drv_oe), 8'hFF);
        @(negedge clk);
        rst = 1'b0;
        pd_req = 1'b0;

        // full sweep: power state x offset x strobes x write byte
        for (int pd = 0; pd < 2; pd++) begin
            for (int o = 0; o < 8; o++) begin
                for (int s = 1; s < 4; s++) begin
                    for (int d = 0; d < 256; d++) begin
                        if (s == 2 || d == 0 || d == 255 || o == 2 || o == 4)
                            one_access(pd[0], s[0], s[1], o, d, 1'b0);
                        else if (s == 1 && d < 8)
                            one_access(pd[0], s[0], s[1], o, d, 1'b0);
                    end
                end
            end
        end

        // same-cycle collision of request with access
        for (int pd = 0; pd < 2; pd++) begin
            one_access(pd[0], 1'b1, 1'b0, 5, 0, 1'b1);   // wake access wins: flag low (R7)
            one_access(pd[0], 1'b1, 1'b0, 0, 0, 1'b1);   // quiet access: flag set (R7)
            one_access(pd[0], 1'b0, 1'b1, 2, 8'h04, 1'b1); // idle drive-control write (R4, R7)
            one_access(pd[0], 1'b0, 1'b1, 4, 8'h80, 1'b1); // rate-select reset (R5, R7)
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule